// File: doc/BRIEF.md
# Paged Command and Interrupt Register Block

This block is the host-facing register front end of a network controller. The host reaches it through a 4-bit register offset with separate write and read strobes. Two bits of the command register choose which register page the offsets 0x1 to 0xF reach. Offset 0x0 always reaches the command register. The same offset can name one register for reads and a different one for writes. The command register carries the stop request (bit 0), the start request (bit 1), the remote DMA command field (bits 5:3) and the page select (bits 7:6).

The receive, transmit, DMA and counter logic report events as one-cycle strobes. The block latches each strobe into an interrupt status register, and software clears a status bit by writing a one to it. A mask register chooses which latched events drive the single interrupt line. A separate status bit records that the controller is halted. A stop command sets it, and software polls it before it reconfigures the controller. That bit never raises an interrupt.

Top module: `nic_regfile`

## Requirements
- R1: After reset, the command register reads 0x21, the status register reads 0x80, the mask register reads 0x00 and `irq` is low.
- R2: Bits 7:6 of the command register select the page for offsets 0x1 to 0xF: 00 is page 0, 01 is page 1, 10 is page 2 and 11 is page 3. Offset 0x0 reaches the command register for reads and writes on every page.
- R3: A strobe on `ev_strobe[i]`, where i is 0 to 6, sets status bit i on the next clock. The bits are: 0 receive ok, 1 transmit ok, 2 receive error, 3 transmit error, 4 ring overwrite warning, 5 tally counter MSB, 6 remote DMA done. The bit stays set until software clears it.
- R4: A write to page 0 offset 0x7 clears every status bit written as 1 and leaves every bit written as 0 unchanged. Writing 0xFF clears all eight bits.
- R5: When an event strobe and a write-one-to-clear of the same status bit fall in the same cycle, the bit stays set.
- R6: A write to page 0 offset 0xF loads the mask register, which uses the status bit positions. A read of page 2 offset 0xF returns the mask. A read of page 0 offset 0xF returns 0x00, because that read reaches a different register that is not held here.
- R7: `irq` is registered. It goes high one cycle after any of status bits 0 to 6 is set while the matching mask bit is set. Status bit 7 never raises `irq`, whatever the mask.
- R8: A command write with bit 0 = 1 sets status bit 7. A command write with bit 1 = 1 and bit 0 = 0 clears it. Status bit 7 can also be cleared by writing a one to it.
- R9: Writes to pages 1 and 3 at offsets 0x1 to 0xF do not change the status or mask registers. Writes to page 0 at offsets other than 0x0, 0x7 and 0xF do not change them either. Reads at any offset that reaches none of the three registers return 0x00.
- R10: Read data appears on `rd_data` in the cycle after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| ev_strobe | input | 7 | One-cycle event strobes, bit i sets status bit i |
| irq | output | 1 | Registered interrupt request |

## Verification
Two functions of this block can act on the same status bit in one cycle: an event strobe sets it and a host write of one clears it. The bench drives the strobe and the clearing write in the same cycle, both for the same bit and for different bits. It then reads the status back and expects the set to win, while any other bit named in the write is cleared. Separately, it sweeps all 256 mask values against each one-hot status source, including the halt bit, and compares `irq` with the value worked out from the mask.

// File: rtl/nic_regfile_pkg.sv
package nic_regfile_pkg;

  localparam int REG_BITS  = 8;
  localparam int ADDR_BITS = 4;
  localparam int EV_COUNT  = 7;

  typedef enum logic [1:0] {
    PG0 = 2'b00,
    PG1 = 2'b01,
    PG2 = 2'b10,
    PG3 = 2'b11
  } page_e;

  localparam logic [ADDR_BITS-1:0] OFS_CMD  = 4'h0;
  localparam logic [ADDR_BITS-1:0] OFS_STAT = 4'h7;
  localparam logic [ADDR_BITS-1:0] OFS_MASK = 4'hF;

  localparam int CMD_STOP_BIT  = 0;
  localparam int CMD_START_BIT = 1;

  localparam logic [REG_BITS-1:0] CMD_INIT  = 8'h21;
  localparam logic [REG_BITS-1:0] STAT_INIT = 8'h80;
  localparam logic [REG_BITS-1:0] MASK_INIT = 8'h00;

  typedef struct packed {
    logic cmd;
    logic stat;
    logic mask;
  } reg_sel_t;

endpackage

// File: rtl/nic_addr_decode.sv
module nic_addr_decode
  import nic_regfile_pkg::*;
#(
  parameter int ADDR_W = ADDR_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  input  page_e             page,
  input  logic              wr_en,
  output reg_sel_t          wsel,
  output reg_sel_t          rsel
);

  logic hit_cmd, hit_stat, hit_mask;

  assign hit_cmd  = (addr == OFS_CMD);
  assign hit_stat = (addr == OFS_STAT);
  assign hit_mask = (addr == OFS_MASK);

  always_comb begin
    // write side: command on any page, status and mask on page 0 only
    wsel.cmd  = wr_en && hit_cmd;
    wsel.stat = wr_en && hit_stat && (page == PG0);
    wsel.mask = wr_en && hit_mask && (page == PG0);
    // read side: the mask offset on page 0 belongs to another register
    rsel.cmd  = hit_cmd;
    rsel.stat = hit_stat && (page == PG0);
    rsel.mask = hit_mask && (page == PG2);
  end

endmodule

// File: rtl/nic_int_status.sv
module nic_int_status
  import nic_regfile_pkg::*;
#(
  parameter int NUM_EV = EV_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] ev,
  input  logic              w1c_en,
  input  logic [NUM_EV:0]   w1c_bits,
  input  logic              halt_set,
  input  logic              halt_clr,
  output logic [NUM_EV:0]   status
);

  localparam int HALT_BIT = NUM_EV;

  logic [NUM_EV:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      st_q[HALT_BIT] <= 1'b1;
    end else begin
      for (int i = 0; i < NUM_EV; i++) begin
        if (ev[i])
          st_q[i] <= 1'b1;
        else if (w1c_en && w1c_bits[i])
          st_q[i] <= 1'b0;
      end
      if (halt_set)
        st_q[HALT_BIT] <= 1'b1;
      else if (halt_clr || (w1c_en && w1c_bits[HALT_BIT]))
        st_q[HALT_BIT] <= 1'b0;
    end
  end

  assign status = st_q;

  // R3 and R5: every strobed event is latched, even against a clearing write
  assert_event_latched_R3: assert property (@(posedge clk) disable iff (rst)
    (|ev) |=> ((status[NUM_EV-1:0] & $past(ev)) == $past(ev)));

  // R4: with no competing set, every bit written as one reads back zero
  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (w1c_en && (ev == '0) && !halt_set) |=> ((status & $past(w1c_bits)) == '0));

endmodule

// File: rtl/nic_irq_gen.sv
module nic_irq_gen #(
  parameter int NUM_EV = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] status,
  input  logic [NUM_EV-1:0] mask,
  output logic              irq
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status & mask);
  end

  assign irq = irq_q;

  // R7: with no enabled pending source the line is low one cycle later
  assert_quiet_when_masked_R7: assert property (@(posedge clk) disable iff (rst)
    ((status & mask) == '0) |=> !irq);

endmodule

// File: rtl/nic_regfile.sv
module nic_regfile
  import nic_regfile_pkg::*;
#(
  parameter int ADDR_W = ADDR_BITS,
  parameter int DATA_W = REG_BITS,
  parameter int NUM_EV = EV_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_EV-1:0] ev_strobe,
  output logic              irq
);

  localparam int HALT_BIT = NUM_EV;
  localparam int PAGE_HI  = DATA_W - 1;
  localparam int PAGE_LO  = DATA_W - 2;

  logic [DATA_W-1:0] cmd_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] rd_q;
  logic [NUM_EV:0]   stat;
  page_e             page;
  reg_sel_t          wsel, rsel;
  logic              halt_set, halt_clr;

  assign page = page_e'(cmd_q[PAGE_HI:PAGE_LO]);

  nic_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr  (addr),
    .page  (page),
    .wr_en (wr_en),
    .wsel  (wsel),
    .rsel  (rsel)
  );

  // command register: page select and controller requests
  always_ff @(posedge clk) begin
    if (rst)           cmd_q <= CMD_INIT;
    else if (wsel.cmd) cmd_q <= wr_data;
  end

  assign halt_set = wsel.cmd && wr_data[CMD_STOP_BIT];
  assign halt_clr = wsel.cmd && wr_data[CMD_START_BIT] && !wr_data[CMD_STOP_BIT];

  nic_int_status #(.NUM_EV(NUM_EV)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev_strobe),
    .w1c_en   (wsel.stat),
    .w1c_bits (wr_data[NUM_EV:0]),
    .halt_set (halt_set),
    .halt_clr (halt_clr),
    .status   (stat)
  );

  // mask register
  always_ff @(posedge clk) begin
    if (rst)            mask_q <= MASK_INIT;
    else if (wsel.mask) mask_q <= wr_data;
  end

  nic_irq_gen #(.NUM_EV(NUM_EV)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .status (stat[NUM_EV-1:0]),
    .mask   (mask_q[NUM_EV-1:0]),
    .irq    (irq)
  );

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      if (rsel.cmd)       rd_q <= cmd_q;
      else if (rsel.stat) rd_q <= DATA_W'(stat);
      else if (rsel.mask) rd_q <= mask_q;
      else                rd_q <= '0;
    end
  end

  assign rd_data = rd_q;

  // R8: a stop request leaves the halt bit set on the next cycle
  assert_stop_sets_halt_R8: assert property (@(posedge clk) disable iff (rst)
    (wsel.cmd && wr_data[CMD_STOP_BIT]) |=> stat[HALT_BIT]);

  // R8: a start request without stop leaves the halt bit clear
  assert_start_clears_halt_R8: assert property (@(posedge clk) disable iff (rst)
    (wsel.cmd && wr_data[CMD_START_BIT] && !wr_data[CMD_STOP_BIT]) |=> !stat[HALT_BIT]);

  // R7: the halt bit alone never raises the interrupt line
  assert_halt_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (stat[HALT_BIT] && (stat[NUM_EV-1:0] == '0)) |=> !irq);

  // R10: with no read strobe the read data holds
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/sim_nic_regfile.sv
`timescale 1ns/1ps
module sim_nic_regfile;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [6:0] ev_strobe = '0;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nic_regfile u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ev_strobe(ev_strobe), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk); ev_strobe = v;
    @(negedge clk); ev_strobe = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] hold;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd(4'h0, v); check("R1 cmd", v, 8'h21);
    rd(4'h7, v); check("R1 status", v, 8'h80);
    wr(4'h0, 8'hA1);
    rd(4'hF, v); check("R1 mask", v, 8'h00);
    rd(4'h0, v); check("R2 cmd on page 2", v, 8'hA1);
    wr(4'h0, 8'h21);

    // R3: each event latches and holds; R4: single-bit clears
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      repeat (2) @(negedge clk);
      rd(4'h7, v); check("R3 latch", v, 8'h80 | 8'(1 << i));
      wr(4'h7, 8'h00);
      rd(4'h7, v); check("R4 zero write keeps", v, 8'h80 | 8'(1 << i));
      wr(4'h7, 8'(1 << i));
      rd(4'h7, v); check("R4 single clear", v, 8'h80);
    end

    // R4: partial and full clear
    pulse(7'h7F);
    wr(4'h7, 8'h55);
    rd(4'h7, v); check("R4 partial clear", v, 8'hAA);
    wr(4'h7, 8'hFF);
    rd(4'h7, v); check("R4 full clear", v, 8'h00);

    // R8: stop/start and the halt bit
    wr(4'h0, 8'h22);
    rd(4'h7, v); check("R8 start keeps clear", v, 8'h00);
    wr(4'h0, 8'h21);
    rd(4'h7, v); check("R8 stop sets", v, 8'h80);
    wr(4'h0, 8'h22);
    rd(4'h7, v); check("R8 start clears", v, 8'h00);
    rd(4'h0, v); check("R2 cmd readback", v, 8'h22);
    wr(4'h0, 8'h21);
    wr(4'h7, 8'h80);
    rd(4'h7, v); check("R8 w1c halt", v, 8'h00);

    // R5: event and clear in the same cycle
    @(negedge clk); addr = 4'h7; wr_data = 8'h04; wr_en = 1'b1; ev_strobe = 7'h04;
    @(negedge clk); wr_en = 1'b0; ev_strobe = '0;
    rd(4'h7, v); check("R5 same bit", v, 8'h04);
    pulse(7'h02);
    @(negedge clk); addr = 4'h7; wr_data = 8'h02; wr_en = 1'b1; ev_strobe = 7'h08;
    @(negedge clk); wr_en = 1'b0; ev_strobe = '0;
    rd(4'h7, v); check("R5 other bits", v, 8'h0C);

    // R9: writes on other pages/offsets do not reach status or mask
    wr(4'h0, 8'h61);             // page 1, sets halt
    wr(4'h7, 8'hFF);
    wr(4'hF, 8'hFF);
    rd(4'h7, v); check("R9 page1 read 7", v, 8'h00);
    wr(4'h0, 8'hE1);             // page 3
    wr(4'h7, 8'hFF);
    rd(4'h7, v); check("R9 page3 read 7", v, 8'h00);
    wr(4'h0, 8'h21);             // page 0
    wr(4'h3, 8'hFF);
    rd(4'h3, v); check("R9 page0 read 3", v, 8'h00);
    rd(4'h7, v); check("R9 status intact", v, 8'h8C);
    wr(4'h0, 8'hA1);
    rd(4'hF, v); check("R9 mask intact", v, 8'h00);
    wr(4'h0, 8'h21);

    // R10: read data holds without rd_en
    rd(4'h7, hold);
    pulse(7'h10);
    repeat (2) @(negedge clk);
    check("R10 hold", rd_data, hold);

    // R6, R7: full mask sweep against one-hot sources
    for (int m = 0; m < 256; m++) begin
      wr(4'hF, 8'(m));
      rd(4'hF, v); check("R6 page0 read F", v, 8'h00);
      wr(4'h0, 8'hA1);
      rd(4'hF, v); check("R6 mask readback", v, 8'(m));
      wr(4'h0, 8'h21);
      for (int i = 0; i < 8; i++) begin
        wr(4'h7, 8'hFF);
        @(negedge clk);
        check("R7 idle", {7'd0, irq}, 8'h00);
        if (i < 7) pulse(7'(1 << i));
        else       wr(4'h0, 8'h21);
        @(negedge clk);
        check("R7 irq", {7'd0, irq}, (i < 7) ? {7'd0, m[i]} : 8'h00);
      end
    end

    finish_run();
  end

endmodule